// File: doc/BRIEF.md
# Tiled Surface Address Walker

This block steps through a rectangle of texels on a 2D surface and produces one byte address for each texel. Software or a copy engine gives it the rectangle's origin in memory coordinates (x in bytes, y in rows), its width and height in texels, the size of a texel in bytes, the surface pitch and the tiling layout. A one-cycle start pulse captures all of this. The block then presents addresses in row-major order on a valid/ready stream, and flags the last address with a done pulse.

Four layouts are supported: plain linear, a row-major 4 KiB tile that is 512 bytes wide, a 4 KiB tile that is 128 bytes wide with its 16-byte units stored column-first, and a 64x64-byte tile built from nested 8x8, 4x4 and 2x2 blocks. Each tiled layout has an optional bit-6 address swizzle of its own. The block only computes addresses. It moves no data.

Top module: `tile_addr_walker`

## Requirements
- R1: After reset, and whenever no box is active, `addr_valid` and `done` are low.
- R2: With `tile_mode` = 0 (linear), the address is y*pitch + x and the swizzle enable has no effect.
- R3: With `tile_mode` = 1 (wide tile, 512 B x 8 rows), the address is T*4096 + (y mod 8)*512 + (x mod 512), where T = (y div 8)*(pitch div 512) + (x div 512).
- R4: With `tile_mode` = 2 (narrow tile, 128 B x 32 rows), T = (y div 32)*(pitch div 128) + (x div 128). The address is T*4096 + U*16 + (x mod 16), where U = ((x mod 128) div 16)*32 + (y mod 32), so 16-byte units are numbered down the columns.
- R5: With `tile_mode` = 3 (block tile, 64 B x 64 rows), T = (y div 64)*(pitch div 64) + (x div 64). The address is T*4096 + B*64 + low. B = ((x mod 64) div 8)*8 + ((y mod 64) div 8). The value low is the 6-bit field {y[2],x[2],y[1],x[1],y[0],x[0]}.
- R6: When `swz_en` is 1 and `tile_mode` = 1, address bit 6 is replaced by bit6 XOR bit9 XOR bit10 of the unswizzled address.
- R7: When `swz_en` is 1 and `tile_mode` is 2 or 3, address bit 6 is replaced by bit6 XOR bit9 of the unswizzled address.
- R8: Addresses come out in row-major order. x advances by `bpp` bytes per texel. At the end of a row, x returns to the origin and y increases by one. One address is accepted in each cycle where `addr_valid` and `addr_ready` are both high.
- R9: While `addr_valid` is high and `addr_ready` is low, `addr_valid` stays high and `addr` holds its value.
- R10: `done` is high together with the last address of a box. After that address is accepted, `addr_valid` falls.
- R11: A start with zero width or zero height produces a single-cycle `done` in the cycle after start, with `addr_valid` low.
- R12: The configuration is captured only by a start pulse seen while idle. A start pulse during an active box, and changes to the configuration inputs, have no effect on that box.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture configuration and begin a box (when idle) |
| org_x | input | 16 | Box origin x in bytes |
| org_y | input | 16 | Box origin y in rows |
| box_w | input | 16 | Box width in texels |
| box_h | input | 16 | Box height in rows |
| bpp | input | 4 | Bytes per texel |
| pitch | input | 16 | Surface pitch in bytes |
| tile_mode | input | 2 | 0 linear, 1 wide tile, 2 narrow tile, 3 block tile |
| swz_en | input | 1 | Bit-6 address swizzle enable |
| addr_valid | output | 1 | Address available |
| addr_ready | input | 1 | Consumer accepts the address |
| addr | output | 32 | Byte address of the current texel |
| done | output | 1 | Marks the last address of a box, or an empty box |

## Verification
The first address becomes valid in the cycle right after the clock edge that samples start, because the counters load on that edge and the address mapping is combinational. Each later address appears in the cycle after the previous handshake. An empty box's done is high for exactly the one cycle after start. The bench computes every expected address from the tile formulas and queues them before it raises start. The monitor sets ready on the falling edge, settles, and then compares only when valid and ready are both high, which is exactly when the next rising edge takes the address. Empty-box, idle and end-of-box checks are sampled on the falling edge that follows the edge where the result is due.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [1:0] {
    TM_LINEAR = 2'd0,
    TM_WIDE   = 2'd1,
    TM_NARROW = 2'd2,
    TM_BLOCK  = 2'd3
  } tile_mode_e;

  localparam int TILE_LG     = 12;  // 4 KiB per tile
  localparam int WIDE_W_LG   = 9;   // 512 bytes
  localparam int WIDE_H_LG   = 3;   // 8 rows
  localparam int NARROW_W_LG = 7;   // 128 bytes
  localparam int NARROW_H_LG = 5;   // 32 rows
  localparam int BLOCK_W_LG  = 6;   // 64 bytes
  localparam int BLOCK_H_LG  = 6;   // 64 rows
  localparam int SWZ_BIT     = 6;
endpackage

// File: rtl/tw_walk.sv
module tw_walk #(
  parameter int CW = 16,
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          adv,
  input  logic [CW-1:0] org_x,
  input  logic [CW-1:0] org_y,
  input  logic [CW-1:0] box_w,
  input  logic [CW-1:0] box_h,
  input  logic [BW-1:0] step,
  output logic [CW-1:0] cur_x,
  output logic [CW-1:0] cur_y,
  output logic          last
);
  logic [CW-1:0] x_q, x_d, y_q, y_d, x0_q, x0_d;
  logic [CW-1:0] wm1_q, wm1_d, col_q, col_d, row_q, row_d;
  logic [BW-1:0] step_q, step_d;
  logic          row_end;

  assign row_end = (col_q == '0);

  always_comb begin
    x_d = x_q; y_d = y_q; x0_d = x0_q; wm1_d = wm1_q;
    col_d = col_q; row_d = row_q; step_d = step_q;
    if (load) begin
      x_d    = org_x;
      y_d    = org_y;
      x0_d   = org_x;
      wm1_d  = box_w - 1'b1;
      col_d  = box_w - 1'b1;
      row_d  = box_h - 1'b1;
      step_d = step;
    end else if (adv) begin
      if (row_end) begin
        x_d   = x0_q;
        y_d   = y_q + 1'b1;
        col_d = wm1_q;
        row_d = row_q - 1'b1;
      end else begin
        x_d   = x_q + {{(CW-BW){1'b0}}, step_q};
        col_d = col_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0; y_q <= '0; x0_q <= '0; wm1_q <= '0;
      col_q <= '0; row_q <= '0; step_q <= '0;
    end else if (load || adv) begin
      x_q <= x_d; y_q <= y_d; x0_q <= x0_d; wm1_q <= wm1_d;
      col_q <= col_d; row_q <= row_d; step_q <= step_d;
    end
  end

  assign cur_x = x_q;
  assign cur_y = y_q;
  assign last  = row_end && (row_q == '0);
endmodule

// File: rtl/tw_map.sv
module tw_map
  import tw_pkg::*;
#(
  parameter int CW = 16,
  parameter int AW = 32
) (
  input  logic [CW-1:0] x,
  input  logic [CW-1:0] y,
  input  logic [CW-1:0] pitch,
  input  tile_mode_e    mode,
  input  logic          swz,
  output logic [AW-1:0] addr
);
  localparam int PADW = AW - CW;
  localparam int HIW  = AW - TILE_LG;

  logic [AW-1:0] xe, ye, pe, tpr, tile, raw;
  logic [TILE_LG-1:0] low;
  logic          flip;

  assign xe = {{PADW{1'b0}}, x};
  assign ye = {{PADW{1'b0}}, y};
  assign pe = {{PADW{1'b0}}, pitch};

  always_comb begin
    tpr  = '0;
    tile = '0;
    low  = '0;
    raw  = ye * pe + xe;
    case (mode)
      TM_WIDE: begin
        tpr  = pe >> WIDE_W_LG;
        tile = (ye >> WIDE_H_LG) * tpr + (xe >> WIDE_W_LG);
        low  = {ye[2:0], xe[8:0]};
      end
      TM_NARROW: begin
        tpr  = pe >> NARROW_W_LG;
        tile = (ye >> NARROW_H_LG) * tpr + (xe >> NARROW_W_LG);
        low  = {xe[6:4], ye[4:0], xe[3:0]};
      end
      TM_BLOCK: begin
        tpr  = pe >> BLOCK_W_LG;
        tile = (ye >> BLOCK_H_LG) * tpr + (xe >> BLOCK_W_LG);
        low  = {xe[5:3], ye[5:3], ye[2], xe[2], ye[1], xe[1], ye[0], xe[0]};
      end
      default: ;
    endcase
    if (mode != TM_LINEAR)
      raw = {tile[HIW-1:0], low};
  end

  always_comb begin
    flip = raw[9];
    if (mode == TM_WIDE)
      flip = raw[9] ^ raw[10];
    addr = raw;
    if (swz && (mode != TM_LINEAR))
      addr[SWZ_BIT] = raw[SWZ_BIT] ^ flip;
  end
endmodule

// File: rtl/tile_addr_walker.sv
module tile_addr_walker
  import tw_pkg::*;
#(
  parameter int CW = 16,
  parameter int BW = 4,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] org_x,
  input  logic [CW-1:0] org_y,
  input  logic [CW-1:0] box_w,
  input  logic [CW-1:0] box_h,
  input  logic [BW-1:0] bpp,
  input  logic [CW-1:0] pitch,
  input  logic [1:0]    tile_mode,
  input  logic          swz_en,
  output logic          addr_valid,
  input  logic          addr_ready,
  output logic [AW-1:0] addr,
  output logic          done
);
  logic          busy_q, busy_d, empty_q, empty_d;
  logic          load, adv, last, zero_box;
  logic [CW-1:0] cur_x, cur_y, pitch_q;
  tile_mode_e    mode_q;
  logic          swz_q;

  assign zero_box = (box_w == '0) || (box_h == '0);
  assign load     = start && !busy_q;
  assign adv      = busy_q && addr_ready;

  always_comb begin
    busy_d  = busy_q;
    empty_d = load && zero_box;
    if (load)
      busy_d = !zero_box;
    else if (adv && last)
      busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      empty_q <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      empty_q <= empty_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pitch_q <= '0;
      mode_q  <= TM_LINEAR;
      swz_q   <= 1'b0;
    end else if (load) begin
      pitch_q <= pitch;
      mode_q  <= tile_mode_e'(tile_mode);
      swz_q   <= swz_en;
    end
  end

  tw_walk #(.CW(CW), .BW(BW)) u_walk (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .adv   (adv),
    .org_x (org_x),
    .org_y (org_y),
    .box_w (box_w),
    .box_h (box_h),
    .step  (bpp),
    .cur_x (cur_x),
    .cur_y (cur_y),
    .last  (last)
  );

  tw_map #(.CW(CW), .AW(AW)) u_map (
    .x     (cur_x),
    .y     (cur_y),
    .pitch (pitch_q),
    .mode  (mode_q),
    .swz   (swz_q),
    .addr  (addr)
  );

  assign addr_valid = busy_q;
  assign done       = (busy_q && last) || empty_q;
endmodule

// File: rtl/tw_chk.sv
module tw_chk #(
  parameter int CW = 16,
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [CW-1:0] box_w,
  input logic [CW-1:0] box_h,
  input logic          addr_valid,
  input logic          addr_ready,
  input logic [AW-1:0] addr,
  input logic          done
);
  // R9: a stalled address stays presented
  a_r9_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && !addr_ready |=> addr_valid);
  // R9: a stalled address keeps its value
  a_r9_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && !addr_ready |=> $stable(addr));
  // R10: accepting the last address ends the box
  a_r10_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && addr_ready && done |=> !addr_valid);
  // R8: an accepted address that is not last is followed by another
  a_r8_stream_on: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && addr_ready && !done |=> addr_valid);
  // R11: empty box gives done without addresses
  a_r11_empty: assert property (@(posedge clk) disable iff (!rst_n)
    start && !addr_valid && ((box_w == '0) || (box_h == '0)) |=> done && !addr_valid);
  // R1: done without a valid address lasts only one cycle
  a_r1_idle_done: assert property (@(posedge clk) disable iff (!rst_n)
    done && !addr_valid && !start |=> !done);
endmodule

bind tile_addr_walker tw_chk #(.CW(CW), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .box_w      (box_w),
  .box_h      (box_h),
  .addr_valid (addr_valid),
  .addr_ready (addr_ready),
  .addr       (addr),
  .done       (done)
);

// File: tb/sim_tile_addr_walker.sv
module sim_tile_addr_walker;
  typedef struct {
    int unsigned a;
    bit          lst;
    string       tag;
  } item_t;

  logic        clk, rst_n, start, swz_en, addr_valid, addr_ready, done;
  logic [15:0] org_x, org_y, box_w, box_h, pitch;
  logic [3:0]  bpp;
  logic [1:0]  tile_mode;
  logic [31:0] addr;

  item_t q[$];
  int    total = 0, bad = 0, cyc = 0, rdy_mode = 0;
  bit    finished = 0;
  logic [31:0] prev_addr;
  bit    prev_stall = 0;

  tile_addr_walker u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .org_x(org_x), .org_y(org_y),
    .box_w(box_w), .box_h(box_h), .bpp(bpp), .pitch(pitch),
    .tile_mode(tile_mode), .swz_en(swz_en), .addr_valid(addr_valid),
    .addr_ready(addr_ready), .addr(addr), .done(done)
  );

  initial clk = 0;
  always #10 clk = ~clk;  // 50 MHz

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int unsigned model(int md, int unsigned x, int unsigned y,
                                        int unsigned p, bit sw);
    int unsigned t, o, b8, b4, b2, b1, s;
    case (md)
      1: begin
        t = (y / 8) * (p / 512) + x / 512;
        o = t * 4096 + (y % 8) * 512 + x % 512;
        s = ((o >> 9) ^ (o >> 10)) & 1;
      end
      2: begin
        t = (y / 32) * (p / 128) + x / 128;
        o = t * 4096 + (((x % 128) / 16) * 32 + y % 32) * 16 + x % 16;
        s = (o >> 9) & 1;
      end
      3: begin
        t  = (y / 64) * (p / 64) + x / 64;
        b8 = ((x % 64) / 8) * 8 + (y % 64) / 8;
        b4 = ((y / 4) % 2) * 2 + (x / 4) % 2;
        b2 = ((y / 2) % 2) * 2 + (x / 2) % 2;
        b1 = (y % 2) * 2 + x % 2;
        o  = t * 4096 + b8 * 64 + b4 * 16 + b2 * 4 + b1;
        s  = (o >> 9) & 1;
      end
      default: begin
        o = y * p + x;
        s = 0;
      end
    endcase
    if (sw && md != 0) o = o ^ (s << 6);
    return o;
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    cyc++;
    if (rdy_mode == 0) addr_ready = 1'b1;
    else addr_ready = !((cyc % 5) == 2 || (cyc % 7) == 3);
    #1;
    if (prev_stall)
      check(addr_valid === 1'b1 && addr === prev_addr, "R9 hold", addr, prev_addr);
    prev_stall = addr_valid && !addr_ready;
    prev_addr  = addr;
    if (addr_valid && addr_ready) begin
      if (q.size() == 0) begin
        check(0, "R10 extra address", addr, 0);
      end else begin
        item_t it;
        it = q.pop_front();
        check(addr === it.a, it.tag, addr, it.a);
        check(done === it.lst, "R10 done flag", done, it.lst);
      end
    end
  end

  task automatic run_box(int md, int ox, int oy, int w, int h, int bp, int p,
                         bit sw, string tag, bit poke);
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++) begin
        item_t it;
        it.a   = model(md, ox + c * bp, oy + r, p, sw);
        it.lst = (r == h - 1) && (c == w - 1);
        it.tag = tag;
        q.push_back(it);
      end
    @(negedge clk);
    org_x = 16'(ox); org_y = 16'(oy); box_w = 16'(w); box_h = 16'(h);
    bpp = 4'(bp); pitch = 16'(p); tile_mode = 2'(md); swz_en = sw; start = 1;
    @(negedge clk);
    start = 0;
    // R12: scramble inputs after capture
    org_x = 16'h0123; org_y = 16'h0777; box_w = 16'd1; box_h = 16'd1;
    bpp = 4'd1; pitch = 16'd64; tile_mode = 2'(md ^ 1); swz_en = !sw;
    if (poke) begin
      @(negedge clk); @(negedge clk);
      start = 1;
      @(negedge clk);
      start = 0;
    end
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
    #2;
    check(addr_valid === 1'b0 && done === 1'b0, "R10 idle after box", addr_valid, 0);
  endtask

  task automatic run_empty(int w, int h);
    @(negedge clk);
    box_w = 16'(w); box_h = 16'(h); start = 1;
    @(negedge clk);
    start = 0;
    #2;
    check(done === 1'b1 && addr_valid === 1'b0, "R11 empty done", {done, addr_valid}, 2'b10);
    @(negedge clk);
    #2;
    check(done === 1'b0 && addr_valid === 1'b0, "R11 empty one cycle", {done, addr_valid}, 2'b00);
  endtask

  initial begin
    rst_n = 0; start = 0; org_x = 0; org_y = 0; box_w = 0; box_h = 0;
    bpp = 1; pitch = 0; tile_mode = 0; swz_en = 0; addr_ready = 1;
    repeat (3) @(negedge clk);
    #2;
    check(addr_valid === 1'b0 && done === 1'b0, "R1 reset idle", {addr_valid, done}, 0);
    rst_n = 1;
    @(negedge clk); #2;
    check(addr_valid === 1'b0 && done === 1'b0, "R1 idle after reset", {addr_valid, done}, 0);

    run_box(0, 3, 2, 5, 3, 4, 256, 1, "R2 linear", 0);
    run_box(1, 500, 5, 6, 5, 4, 2048, 0, "R3 wide tile", 0);
    run_box(2, 120, 30, 4, 4, 4, 512, 0, "R4 narrow tile", 0);
    run_box(3, 60, 62, 8, 4, 1, 256, 0, "R5 block tile", 0);
    rdy_mode = 1;
    run_box(1, 500, 5, 6, 5, 4, 2048, 1, "R6 wide swizzle", 0);
    run_box(1, 1000, 3, 4, 9, 8, 4096, 1, "R6 wide swizzle bit10", 0);
    run_box(2, 8, 60, 10, 3, 2, 512, 1, "R7 narrow swizzle", 0);
    run_box(3, 60, 62, 8, 4, 1, 256, 1, "R7 block swizzle", 0);
    run_box(0, 7, 1, 3, 4, 3, 96, 0, "R8 order bpp3 stalled", 0);
    run_box(2, 16, 2, 12, 6, 2, 256, 0, "R12 start while busy", 1);
    rdy_mode = 0;
    run_empty(0, 4);
    run_empty(5, 0);
    run_box(3, 0, 0, 1, 1, 1, 64, 0, "R10 single texel", 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule